// File: doc/BRIEF.md
# Memory protection region configuration bank

A bank of configuration registers for a small set of memory protection regions, reached through a simple word-wide register port. Three registers are visible. The selector register picks the region that later accesses act on. The base register holds that region's start address. The attribute register holds the region's size code, its enable, eight subregion disable bits and a 16-bit attribute field. Base writes can also move the selector, so one write can both pick a region and program its base.

Each region keeps its own base and attribute state. A lookup port takes an address and a region index and reports whether the address falls inside that region. The region must be enabled, the address bits above the region size must match the stored base, and the eighth of the region that the address lands in must not be disabled. Nothing here produces faults, checks permissions or ranks overlapping regions. Those jobs belong to the logic that consumes `lk_hit_o`.

Register select codes on `wr_sel_i` and `rd_sel_i`: 0 is the selector, 1 is the base, 2 is the attribute register and 3 is unused. Reads are combinational. Writes take effect at the rising clock edge.

Top module: `mpu_region_bank`

## Requirements
- R1: After reset, the selector reads 0, the base reads 0x00000000 and the attribute reads 0x00000000. No lookup hits in any region.
- R2: A selector write (select 0) loads wr_data_i[3:0] when the value is below NUM_REGIONS (8). A value of 8 or more leaves the selector unchanged. The selector reads back in bits [3:0], and bits [31:4] read zero.
- R3: A base write (select 1) with wr_data_i[4] = 0 writes bits [31:5] into the currently selected region. The selector is unchanged and wr_data_i[3:0] is ignored.
- R4: A base write with wr_data_i[4] = 1 and wr_data_i[3:0] below 8 loads the selector with wr_data_i[3:0] and writes the base of that region. If wr_data_i[3:0] is 8 or more, the whole write is ignored.
- R5: Reading the base register returns the stored base in bits [31:N], where N = SIZE+1. Bits [N-1:5] and bit 4 read zero, and bits [3:0] return the selector.
- R6: Attribute writes (select 2) apply to the selected region by halfword. wr_be_i[0] enables the lower halfword and wr_be_i[1] enables the upper halfword. The layout is: [31:16] attributes, [15:8] subregion disables, [5:1] SIZE, [0] enable. Bits [7:6] read zero.
- R7: lk_hit_o is 1 when region lk_region_i is enabled, its SIZE is 7 or more, and lk_addr_i[31:N] equals the stored base bits [31:N].
- R8: A hit is suppressed when subregion disable bit k is set, where k = lk_addr_i[N-1:N-3].
- R9: A region with SIZE below 7 never hits, even when it is enabled.
- R10: SIZE = 31 (4 GB) stores no base bits. The base reads 0 apart from the selector bits, and every address hits unless its subregion is disabled.
- R11: Select 3 reads zero. Writes to select 3 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 2 | Write register select |
| wr_be_i | input | 2 | Halfword enables for attribute writes |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 2 | Read register select |
| rd_data_o | output | 32 | Read data (combinational) |
| lk_addr_i | input | 32 | Lookup address |
| lk_region_i | input | 3 | Lookup region index |
| lk_hit_o | output | 1 | Address lies inside the enabled region |

## Verification
The bench builds the bank with the default of eight regions. With eight regions, selector values 8 to 15 fall outside the bank, so the out-of-range paths for both selector writes and retargeting base writes can be exercised through the four-bit field. The regions programmed by the bench cover three size cases: the smallest size that can hit (256 bytes), a mid-size 64 KB region with a disabled subregion, and the 4 GB case with no base bits. A below-minimum size is also programmed, so the edges of the base mask and of the subregion index can be observed at the lookup port.

// File: rtl/mpu_bank_pkg.sv
package mpu_bank_pkg;
  localparam int unsigned ADDR_W = 32;

  localparam logic [1:0] SEL_NUM  = 2'd0;
  localparam logic [1:0] SEL_BASE = 2'd1;
  localparam logic [1:0] SEL_ATTR = 2'd2;

  localparam logic [4:0] MIN_SIZE = 5'd7;

  typedef struct packed {
    logic [15:0] attr;
    logic [7:0]  srd;
    logic [4:0]  size;
    logic        en;
  } region_cfg_t;

  // address bits that take part in the base compare for a given size code
  function automatic logic [ADDR_W-1:0] base_mask(input logic [4:0] size);
    logic [5:0] n;
    n = {1'b0, size} + 6'd1;
    if (n >= 6'd32) return '0;
    return ~((32'h1 << n) - 32'h1) & 32'hFFFF_FFE0;
  endfunction
endpackage

// File: rtl/mpu_region_num.sv
module mpu_region_num
  import mpu_bank_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8,
  localparam int unsigned IDX_W = $clog2(NUM_REGIONS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             num_we_i,
  input  logic             base_we_i,
  input  logic [31:0]      wdata_i,
  output logic [IDX_W-1:0] cur_idx_o,
  output logic [IDX_W-1:0] tgt_idx_o,
  output logic             tgt_ok_o
);
  localparam logic [4:0] NUM_L = 5'(NUM_REGIONS);

  logic [3:0]       req;
  logic             req_ok;
  logic             retarget;
  logic [IDX_W-1:0] cur_q;

  assign req      = wdata_i[3:0];
  assign req_ok   = {1'b0, req} < NUM_L;
  assign retarget = base_we_i & wdata_i[4];

  assign tgt_idx_o = retarget ? req[IDX_W-1:0] : cur_q;
  assign tgt_ok_o  = retarget ? req_ok : 1'b1;
  assign cur_idx_o = cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              cur_q <= '0;
    else if ((num_we_i || retarget) && req_ok) cur_q <= req[IDX_W-1:0];
  end
endmodule

// File: rtl/mpu_region_slot.sv
module mpu_region_slot
  import mpu_bank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              base_we_i,
  input  logic [1:0]        attr_be_i,
  input  logic [31:0]       wdata_i,
  input  logic [ADDR_W-1:0] lk_addr_i,
  output logic [31:0]       base_rd_o,
  output logic [31:0]       attr_rd_o,
  output logic              hit_o
);
  logic [31:5]       base_q;
  region_cfg_t       cfg_q;
  logic [ADDR_W-1:0] mask;
  logic [ADDR_W-1:0] base_full;
  logic [5:0]        shamt;
  logic [ADDR_W-1:0] sub_sh;
  logic [2:0]        sub_idx;
  logic              size_ok;
  logic              match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cfg_q  <= '0;
    end else begin
      if (base_we_i) base_q <= wdata_i[31:5];
      if (attr_be_i[0]) begin
        cfg_q.srd  <= wdata_i[15:8];
        cfg_q.size <= wdata_i[5:1];
        cfg_q.en   <= wdata_i[0];
      end
      if (attr_be_i[1]) cfg_q.attr <= wdata_i[31:16];
    end
  end

  assign mask      = base_mask(cfg_q.size);
  assign base_full = {base_q, 5'b0};
  assign base_rd_o = base_full & mask;
  assign attr_rd_o = {cfg_q.attr, cfg_q.srd, 2'b00, cfg_q.size, cfg_q.en};

  // subregion index sits at bits [N-1:N-3], i.e. shift by SIZE-2
  assign shamt   = {1'b0, cfg_q.size} - 6'd2;
  assign sub_sh  = lk_addr_i >> shamt;
  assign sub_idx = sub_sh[2:0];
  assign size_ok = cfg_q.size >= MIN_SIZE;
  assign match   = ((lk_addr_i ^ base_full) & mask) == '0;
  assign hit_o   = cfg_q.en && size_ok && match && !cfg_q.srd[sub_idx];
endmodule

// File: rtl/mpu_region_bank.sv
module mpu_region_bank
  import mpu_bank_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8,
  localparam int unsigned IDX_W = $clog2(NUM_REGIONS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [1:0]        wr_be_i,
  input  logic [31:0]       wr_data_i,
  input  logic [1:0]        rd_sel_i,
  output logic [31:0]       rd_data_o,
  input  logic [ADDR_W-1:0] lk_addr_i,
  input  logic [IDX_W-1:0]  lk_region_i,
  output logic              lk_hit_o
);
  logic [IDX_W-1:0] cur_idx;
  logic [IDX_W-1:0] tgt_idx;
  logic             tgt_ok;
  logic             num_we;
  logic             base_we;
  logic             attr_we;

  logic [31:0]            base_rd_v [NUM_REGIONS];
  logic [31:0]            attr_rd_v [NUM_REGIONS];
  logic [NUM_REGIONS-1:0] hit_v;

  assign num_we  = wr_en_i && (wr_sel_i == SEL_NUM);
  assign base_we = wr_en_i && (wr_sel_i == SEL_BASE);
  assign attr_we = wr_en_i && (wr_sel_i == SEL_ATTR);

  mpu_region_num #(.NUM_REGIONS(NUM_REGIONS)) u_num (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .num_we_i  (num_we),
    .base_we_i (base_we),
    .wdata_i   (wr_data_i),
    .cur_idx_o (cur_idx),
    .tgt_idx_o (tgt_idx),
    .tgt_ok_o  (tgt_ok)
  );

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_slot
    logic       slot_base_we;
    logic [1:0] slot_attr_be;
    assign slot_base_we = base_we && tgt_ok && (tgt_idx == IDX_W'(i));
    assign slot_attr_be = (attr_we && (cur_idx == IDX_W'(i))) ? wr_be_i : 2'b00;

    mpu_region_slot u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .base_we_i (slot_base_we),
      .attr_be_i (slot_attr_be),
      .wdata_i   (wr_data_i),
      .lk_addr_i (lk_addr_i),
      .base_rd_o (base_rd_v[i]),
      .attr_rd_o (attr_rd_v[i]),
      .hit_o     (hit_v[i])
    );
  end

  logic [3:0] num_rd;
  assign num_rd = 4'(cur_idx);

  always_comb begin
    unique case (rd_sel_i)
      SEL_NUM:  rd_data_o = {28'b0, num_rd};
      SEL_BASE: rd_data_o = base_rd_v[cur_idx] | {28'b0, num_rd};
      SEL_ATTR: rd_data_o = attr_rd_v[cur_idx];
      default:  rd_data_o = '0;
    endcase
  end

  assign lk_hit_o = hit_v[lk_region_i];
endmodule

// File: rtl/mpu_region_bank_chk.sv
module mpu_region_bank_chk #(
  parameter int unsigned NUM_REGIONS = 8,
  localparam int unsigned IDX_W = $clog2(NUM_REGIONS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [1:0]       wr_sel_i,
  input logic [31:0]      wr_data_i,
  input logic [1:0]       rd_sel_i,
  input logic [31:0]      rd_data_o,
  input logic [IDX_W-1:0] cur_idx
);
  localparam logic [4:0] NUM_L = 5'(NUM_REGIONS);

  logic in_range;
  assign in_range = {1'b0, wr_data_i[3:0]} < NUM_L;

  a_r2_bad_num_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 2'd0 && !in_range) |=> $stable(cur_idx));

  a_r3_no_retarget: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 2'd1 && !wr_data_i[4]) |=> $stable(cur_idx));

  a_r4_retarget: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 2'd1 && wr_data_i[4] && in_range)
      |=> cur_idx == $past(wr_data_i[IDX_W-1:0]));

  a_r5_base_low_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_sel_i == 2'd1) |-> (rd_data_o[4] == 1'b0 && rd_data_o[3:0] == 4'(cur_idx)));

  a_r6_attr_rsvd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_sel_i == 2'd2) |-> rd_data_o[7:6] == 2'b00);

  a_r11_unused_sel_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_sel_i == 2'd3) |-> rd_data_o == 32'h0);
endmodule

bind mpu_region_bank mpu_region_bank_chk #(.NUM_REGIONS(NUM_REGIONS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_sel_i  (wr_sel_i),
  .wr_data_i (wr_data_i),
  .rd_sel_i  (rd_sel_i),
  .rd_data_o (rd_data_o),
  .cur_idx   (cur_idx)
);

// File: tb/mpu_region_bank_test.sv
`timescale 1ns/1ps
module mpu_region_bank_test;
  localparam int CLK_NS = 20;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [1:0]  wr_be = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic [31:0] lk_addr = '0;
  logic [2:0]  lk_region = '0;
  logic        lk_hit;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  mpu_region_bank uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en),
    .wr_sel_i    (wr_sel),
    .wr_be_i     (wr_be),
    .wr_data_i   (wr_data),
    .rd_sel_i    (rd_sel),
    .rd_data_o   (rd_data),
    .lk_addr_i   (lk_addr),
    .lk_region_i (lk_region),
    .lk_hit_o    (lk_hit)
  );

  typedef struct packed {
    logic [2:0]  rgn;
    logic [31:0] addr;
    logic        exp;
    logic [3:0]  req;
  } vec_t;

  // lookups after setup: r5 = 64KB @0x00010000 with eighth 2 disabled,
  // r1 = 4GB, r2 = size 6 enabled, r3 = 256B @0x00000300, r0 untouched
  localparam vec_t VECS [14] = '{
    '{3'd5, 32'h0001_0000, 1'b1, 4'd7},   // R7 bottom
    '{3'd5, 32'h0001_FFFF, 1'b1, 4'd7},   // R7 top
    '{3'd5, 32'h0002_0000, 1'b0, 4'd7},   // R7 above
    '{3'd5, 32'h0000_FFFF, 1'b0, 4'd7},   // R7 below
    '{3'd5, 32'h0001_4000, 1'b0, 4'd8},   // R8 eighth 2 start
    '{3'd5, 32'h0001_5FFF, 1'b0, 4'd8},   // R8 eighth 2 end
    '{3'd5, 32'h0001_2000, 1'b1, 4'd8},   // R8 eighth 1 live
    '{3'd1, 32'hFFFF_FFF0, 1'b1, 4'd10},  // R10
    '{3'd1, 32'h0000_0000, 1'b1, 4'd10},  // R10
    '{3'd2, 32'h0000_0000, 1'b0, 4'd9},   // R9
    '{3'd3, 32'h0000_0300, 1'b1, 4'd7},   // R7 minimum size
    '{3'd3, 32'h0000_03FF, 1'b1, 4'd7},   // R7
    '{3'd3, 32'h0000_0400, 1'b0, 4'd7},   // R7
    '{3'd0, 32'h0001_0000, 1'b0, 4'd1}    // R1 region never programmed
  };

  task automatic wr(input logic [1:0] sel, input logic [31:0] d, input logic [1:0] be);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d; wr_be = be;
    @(negedge clk);
    wr_en = 1'b0; wr_be = 2'b00;
  endtask

  task automatic chk_rd(input logic [1:0] sel, input logic [31:0] exp, input string tag);
    rd_sel = sel;
    #2;
    n_tests++;
    if (rd_data !== exp) begin
      n_fail++;
      $display("FAIL %s: read sel %0d got %08h exp %08h", tag, sel, rd_data, exp);
    end
  endtask

  task automatic chk_hit(input logic [2:0] r, input logic [31:0] a, input logic exp, input string tag);
    lk_region = r; lk_addr = a;
    #2;
    n_tests++;
    if (lk_hit !== exp) begin
      n_fail++;
      $display("FAIL %s: region %0d addr %08h hit %b exp %b", tag, r, a, lk_hit, exp);
    end
  endtask

  initial begin
    #(CLK_NS * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, got timeout exp completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_rd(2'd0, 32'h0, "R1 selector");
    chk_rd(2'd1, 32'h0, "R1 base");
    chk_rd(2'd2, 32'h0, "R1 attr");
    chk_hit(3'd0, 32'h0, 1'b0, "R1 lookup");

    // R2 selector writes
    wr(2'd0, 32'hFFFF_FFF3, 2'b11);
    chk_rd(2'd0, 32'h3, "R2 load 3");
    wr(2'd0, 32'h0000_0009, 2'b11);
    chk_rd(2'd0, 32'h3, "R2 ignore 9");

    // R4 retargeting base write to region 5
    wr(2'd1, 32'h0001_0015, 2'b11);
    chk_rd(2'd0, 32'h5, "R4 selector moved");

    // R6 halfword attribute writes on region 5
    wr(2'd2, 32'hABCD_001F, 2'b01);
    chk_rd(2'd2, 32'h0000_001F, "R6 lower only");
    wr(2'd2, 32'h1234_FFFF, 2'b10);
    chk_rd(2'd2, 32'h1234_001F, "R6 upper only");
    wr(2'd2, 32'h0000_04DF, 2'b01);
    chk_rd(2'd2, 32'h1234_041F, "R6 reserved bits");
    chk_rd(2'd1, 32'h0001_0005, "R5 base read");

    // R3 plain base write, misaligned bits masked by R5
    wr(2'd1, 32'h0001_2342, 2'b11);
    chk_rd(2'd0, 32'h5, "R3 selector kept");
    chk_rd(2'd1, 32'h0001_0005, "R5 low bits masked");

    // R4 out-of-range retarget is dropped
    wr(2'd1, 32'h0005_0018, 2'b11);
    chk_rd(2'd0, 32'h5, "R4 bad region selector");
    chk_rd(2'd1, 32'h0001_0005, "R4 bad region base");

    // remaining regions
    wr(2'd1, 32'h0000_0011, 2'b11);
    wr(2'd2, 32'h0000_003F, 2'b01);
    wr(2'd1, 32'h0000_0012, 2'b11);
    wr(2'd2, 32'h0000_000D, 2'b01);
    wr(2'd1, 32'h0000_0313, 2'b11);
    wr(2'd2, 32'h0000_000F, 2'b01);
    chk_rd(2'd1, 32'h0000_0303, "R5 min size base");

    for (int i = 0; i < 14; i++) begin
      vec_t v;
      string tag;
      v = VECS[i];
      tag = $sformatf("R%0d vec %0d", v.req, i);
      chk_hit(v.rgn, v.addr, v.exp, tag);
    end

    // R10 full map reads no base bits
    wr(2'd0, 32'h0000_0001, 2'b11);
    chk_rd(2'd1, 32'h0000_0001, "R10 base read");
    wr(2'd1, 32'hFFFF_FFE0, 2'b11);
    chk_rd(2'd1, 32'h0000_0001, "R10 base after write");
    chk_hit(3'd1, 32'h8000_0000, 1'b1, "R10 lookup");

    // R9 size 6 enabled still misses at its own base
    chk_hit(3'd2, 32'h0000_0010, 1'b0, "R9 small size");

    // R11 unused select
    wr(2'd3, 32'hFFFF_FFF6, 2'b11);
    chk_rd(2'd3, 32'h0, "R11 read zero");
    chk_rd(2'd0, 32'h1, "R11 selector kept");
    chk_rd(2'd2, 32'h0000_003F, "R11 attr kept");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule